// File: doc/BRIEF.md
# Overlapping Three-Phase Zone Clock Sequencer

This block turns one system clock into three phase enables for a fabric split into clock zones. Every zone in that fabric is driven by one of the three enables. The phases take turns in a fixed ring: first, second, third, and then first again. Each phase owns a slot of a programmable number of system-clock cycles. One full period of the ring is therefore three slots long.

In overlap mode, the phase that owns a new slot is raised at the slot boundary. The phase that owned the previous slot is then kept high for a programmable number of extra cycles before it is released. A zone is therefore never released until its successor is already active. In non-overlap mode, the hand-off is clean: one phase drops on the same edge that the next one rises.

Besides the enables, the block gives two more outputs:
- a one-cycle strobe each time the first phase rises, which marks the start of a period;
- a role code for each zone (reset, switch or hold), so that the surrounding logic knows which zone is being cleared, which is taking new input, and which is holding its value.

There is no data stream through this block. All pins are plain control or status lines with no handshake.

Top module: `ph3_clock_sequencer`

## Requirements
- R1: The phases become active in the ring order 0, 1, 2, 0, and so on (`phase_en` bit 0 first). After the synchronous reset is released with `en` high, bit 0 is the first to rise, on the first clock edge.
- R2: With `en` held high, each slot lasts the latched slot length in cycles. Consecutive `cycle_start` pulses are therefore three slot lengths apart.
- R3: In overlap mode, the phase of the new slot rises at the slot boundary. The previous phase stays high for the latched overlap count of cycles and then falls. No previous phase is held over in the first slot after reset.
- R4: In non-overlap mode (`overlap_on` = 0), exactly one bit of `phase_en` is high at any time after start-up. The hand-off between phases happens on a single edge.
- R5: A slot length of 0 is treated as 1. In overlap mode, an overlap count that is greater than or equal to the slot length is clamped to the slot length minus one.
- R6: While `rst` is sampled high, on the following edge `phase_en` becomes 000, `cycle_start` becomes 0, and every role becomes hold (code 0).
- R7: `cycle_start` is high for exactly one cycle, in the cycle where `phase_en[0]` has just risen.
- R8: No more than two bits of `phase_en` are ever high together.
- R9: Role codes are 0 = hold, 1 = switch, 2 = reset. Zone g occupies bits [2g+1:2g] of `zone_role`. The zone that owns the current slot reports reset, the zone before it in the ring reports switch, and the zone before that reports hold.
- R10: While `en` is low, the sequencer freezes. `phase_en` and `zone_role` keep their values and no new `cycle_start` is produced.
- R11: The slot length, the overlap count and the mode are sampled only when a slot begins. A change made in the middle of a slot first takes effect at the next slot boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low freezes the sequencer |
| overlap_on | input | 1 | 1 selects overlapping hand-off, 0 selects strictly sequential |
| high_cycles | input | CW | Slot length in clock cycles |
| ovl_cycles | input | CW | Overlap length in clock cycles |
| phase_en | output | 3 | Phase enables, bit g drives zone g |
| cycle_start | output | 1 | One-cycle pulse on each rise of phase_en[0] |
| zone_role | output | 6 | Role code per zone, 2 bits per zone |

## Verification
The hardest cases to reach are those where the configuration inputs change in the middle of a slot. In those cases the old and new settings must not be mixed within a single slot. The same applies to overlap counts at or beyond the slot length, where the clamp decides whether three phases could ever be high at once.

The stimulus handles this in two ways:
- It changes the slot length, the overlap count and the mode at points that are not slot boundaries, and it pauses `en` partway through an overlap window.
- It runs with an overlap count above the slot length and with a slot length of zero and of one.

A cycle-accurate reference model in the bench predicts every output on every cycle of these runs.

// File: rtl/ph3_seq_pkg.sv
package ph3_seq_pkg;
  localparam int NPH = 3;

  typedef enum logic [1:0] {
    ROLE_HOLD   = 2'd0,
    ROLE_SWITCH = 2'd1,
    ROLE_RESET  = 2'd2
  } zone_role_t;

  function automatic logic [1:0] ring_prev(input logic [1:0] s);
    return (s == 2'd0) ? 2'd2 : s - 2'd1;
  endfunction

  function automatic logic [1:0] ring_next(input logic [1:0] s);
    return (s == 2'd2) ? 2'd0 : s + 2'd1;
  endfunction
endpackage

// File: rtl/ph3_cfg_clamp.sv
module ph3_cfg_clamp #(
  parameter int CW = 8
) (
  input  logic [CW-1:0] high_in,
  input  logic [CW-1:0] ovl_in,
  input  logic          overlap_on,
  output logic [CW-1:0] high_eff,
  output logic [CW-1:0] ovl_eff
);
  localparam logic [CW-1:0] ONE = CW'(1);

  always_comb begin
    high_eff = (high_in == '0) ? ONE : high_in;
    if (!overlap_on)
      ovl_eff = '0;
    else if (ovl_in >= high_eff)
      ovl_eff = high_eff - ONE;
    else
      ovl_eff = ovl_in;
  end
endmodule

// File: rtl/ph3_slot_timer.sv
module ph3_slot_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] high_eff,
  input  logic [CW-1:0] ovl_eff,
  output logic          running,
  output logic [1:0]    slot,
  output logic          tail_on
);
  import ph3_seq_pkg::*;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, high_q, ovl_q;
  logic          handed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      running  <= 1'b0;
      slot     <= 2'd0;
      cnt_q    <= '0;
      high_q   <= ONE;
      ovl_q    <= '0;
      handed_q <= 1'b0;
    end else if (en) begin
      if (!running) begin
        running  <= 1'b1;
        slot     <= 2'd0;
        cnt_q    <= '0;
        high_q   <= high_eff;
        ovl_q    <= ovl_eff;
        handed_q <= 1'b0;
      end else if (cnt_q == high_q - ONE) begin
        slot     <= ring_next(slot);
        cnt_q    <= '0;
        high_q   <= high_eff;
        ovl_q    <= ovl_eff;
        handed_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + ONE;
      end
    end
  end

  assign tail_on = running && handed_q && (cnt_q < ovl_q);
endmodule

// File: rtl/ph3_phase_decode.sv
module ph3_phase_decode (
  input  logic       running,
  input  logic [1:0] slot,
  input  logic       tail_on,
  output logic [2:0] phase_en,
  output logic [5:0] zone_role
);
  import ph3_seq_pkg::*;

  logic [1:0] prev_slot;
  assign prev_slot = ring_prev(slot);

  for (genvar g = 0; g < NPH; g++) begin : g_zone
    logic owner, trailing;
    assign owner    = running && (slot == 2'(g));
    assign trailing = running && (prev_slot == 2'(g));
    assign phase_en[g] = owner || (trailing && tail_on);

    zone_role_t role;
    always_comb begin
      if (owner)         role = ROLE_RESET;
      else if (trailing) role = ROLE_SWITCH;
      else               role = ROLE_HOLD;
    end
    assign zone_role[2*g+1:2*g] = role;
  end
endmodule

// File: rtl/ph3_clock_sequencer.sv
module ph3_clock_sequencer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          overlap_on,
  input  logic [CW-1:0] high_cycles,
  input  logic [CW-1:0] ovl_cycles,
  output logic [2:0]    phase_en,
  output logic          cycle_start,
  output logic [5:0]    zone_role
);
  logic [CW-1:0] high_eff, ovl_eff;
  logic          running, tail_on;
  logic [1:0]    slot;
  logic          ph0_q;

  ph3_cfg_clamp #(.CW(CW)) u_clamp (
    .high_in(high_cycles), .ovl_in(ovl_cycles), .overlap_on(overlap_on),
    .high_eff(high_eff), .ovl_eff(ovl_eff)
  );

  ph3_slot_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .en(en),
    .high_eff(high_eff), .ovl_eff(ovl_eff),
    .running(running), .slot(slot), .tail_on(tail_on)
  );

  ph3_phase_decode u_decode (
    .running(running), .slot(slot), .tail_on(tail_on),
    .phase_en(phase_en), .zone_role(zone_role)
  );

  always_ff @(posedge clk) begin
    if (rst) ph0_q <= 1'b0;
    else     ph0_q <= phase_en[0];
  end

  assign cycle_start = phase_en[0] && !ph0_q;
endmodule

// File: rtl/ph3_seq_chk.sv
module ph3_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] phase_en,
  input logic       cycle_start
);
  logic rst_q = 1'b1;
  always_ff @(posedge clk) rst_q <= rst;

  a_r8_two_max: assert property (@(posedge clk) disable iff (rst)
    $countones(phase_en) <= 2);

  a_r1_order_p1: assert property (@(posedge clk) disable iff (rst || rst_q)
    $rose(phase_en[1]) |-> $past(phase_en[0]));

  a_r1_order_p2: assert property (@(posedge clk) disable iff (rst || rst_q)
    $rose(phase_en[2]) |-> $past(phase_en[1]));

  a_r3_handoff: assert property (@(posedge clk) disable iff (rst || rst_q)
    $fell(phase_en[0]) |-> phase_en[1]);

  a_r7_strobe_once: assert property (@(posedge clk) disable iff (rst)
    cycle_start |=> !cycle_start);

  a_r7_strobe_phase: assert property (@(posedge clk) disable iff (rst)
    cycle_start |-> phase_en[0]);

  a_r6_reset_quiet: assert property (@(posedge clk)
    rst |=> (phase_en == 3'b000 && !cycle_start));
endmodule

bind ph3_clock_sequencer ph3_seq_chk u_chk (
  .clk(clk), .rst(rst), .phase_en(phase_en), .cycle_start(cycle_start)
);

// File: tb/tb_ph3_clock_sequencer.sv
module tb_ph3_clock_sequencer;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b1;
  logic          overlap_on = 1'b1;
  logic [CW-1:0] high_cycles = 8'd4;
  logic [CW-1:0] ovl_cycles = 8'd2;
  logic [2:0]    phase_en;
  logic          cycle_start;
  logic [5:0]    zone_role;

  ph3_clock_sequencer #(.CW(CW)) dut (
    .clk(clk), .rst(rst), .en(en), .overlap_on(overlap_on),
    .high_cycles(high_cycles), .ovl_cycles(ovl_cycles),
    .phase_en(phase_en), .cycle_start(cycle_start), .zone_role(zone_role)
  );

  always #10 clk = ~clk;

  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;

  logic [9:0] exp_q[$];
  string      tag_q[$];

  // reference model state
  bit m_run = 0, m_handed = 0;
  int m_slot = 0, m_cnt = 0, m_h = 1, m_o = 0;
  logic [2:0] m_phase = 3'b000;

  task automatic step(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [2:0] old_phase, p;
      logic [5:0] roles;
      int he, oe, pv;
      he = (high_cycles == 0) ? 1 : int'(high_cycles);
      oe = !overlap_on ? 0 : ((int'(ovl_cycles) >= he) ? he - 1 : int'(ovl_cycles));
      old_phase = m_phase;
      if (rst) begin
        m_run = 0; m_slot = 0; m_cnt = 0; m_h = 1; m_o = 0; m_handed = 0;
      end else if (en) begin
        if (!m_run) begin
          m_run = 1; m_slot = 0; m_cnt = 0; m_h = he; m_o = oe; m_handed = 0;
        end else if (m_cnt == m_h - 1) begin
          m_slot = (m_slot + 1) % 3; m_cnt = 0; m_h = he; m_o = oe; m_handed = 1;
        end else begin
          m_cnt++;
        end
      end
      p = 3'b000;
      roles = 6'd0;
      pv = (m_slot + 2) % 3;
      if (m_run) begin
        p[m_slot] = 1'b1;
        if (m_handed && m_cnt < m_o) p[pv] = 1'b1;
        roles[2*m_slot +: 2] = 2'd2;
        roles[2*pv +: 2] = 2'd1;
      end
      m_phase = p;
      exp_q.push_back({p, p[0] & ~old_phase[0], roles});
      tag_q.push_back(tag);
      @(negedge clk);
    end
  endtask

  // monitor
  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      logic [9:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      vectors++;
      if ({phase_en, cycle_start, zone_role} !== e) begin
        misses++;
        $display("FAIL %s: phase=%b start=%b roles=%b expected phase=%b start=%b roles=%b",
                 t, phase_en, cycle_start, zone_role, e[9:7], e[6], e[5:0]);
      end
      vectors++;
      if ($countones(phase_en) > 2) begin
        misses++;
        $display("FAIL R8: phase=%b has %0d active, expected at most 2",
                 phase_en, $countones(phase_en));
      end
    end
  end

  initial begin
    @(negedge clk);
    // R6: reset state
    step(3, "R6");
    // R1 R2 R3 R7 R9: overlap mode, slot 4, overlap 2
    rst = 1'b0;
    step(40, "R1,R2,R3,R7,R9");
    // R6: reset in the middle of a run
    rst = 1'b1;
    step(2, "R6");
    // R4: non-overlap, slot 3
    rst = 1'b0; overlap_on = 1'b0; high_cycles = 8'd3;
    step(30, "R4");
    // R5: overlap too large is clamped
    rst = 1'b1; step(1, "R6");
    rst = 1'b0; overlap_on = 1'b1; high_cycles = 8'd4; ovl_cycles = 8'd9;
    step(30, "R5");
    // R10: freeze partway through an overlap window
    step(13, "R5");
    en = 1'b0;
    step(6, "R10");
    en = 1'b1;
    step(10, "R10");
    // R11: settings changed mid-slot
    high_cycles = 8'd5; ovl_cycles = 8'd1;
    step(2, "R11");
    overlap_on = 1'b0;
    step(2, "R11");
    overlap_on = 1'b1; ovl_cycles = 8'd3;
    step(36, "R11");
    // R5: slot length zero behaves as one
    rst = 1'b1; step(1, "R6");
    rst = 1'b0; high_cycles = 8'd0; ovl_cycles = 8'd0;
    step(12, "R5");
    // R8: slot length one with large overlap request
    high_cycles = 8'd1; ovl_cycles = 8'd5;
    step(12, "R8");
    step(1, "R8");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      misses++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule